// File: doc/BRIEF.md
# Discrete-Input Sense Register Port

This block is the serial register front end of a 32-channel discrete-input sense device. An external host runs SPI mode 0 transactions against it. The first byte of every transaction is a command: its top bit chooses between a read and a write, and its seven low bits give the register address. Data bytes that follow are carried most significant byte first in both directions.

The block keeps a small configuration space and drives its contents onto output pins for the analog sense core. That space holds a control register with a test-mode flag and a soft-reset flag, a sense-mode register with one bit per bank of eight channels (ground-open or supply-open sensing), and two 16-bit threshold words, one for each sensing mode. It also offers read-only views of the live channel states, which arrive on a 32-bit input bus: either the whole word or one byte lane at a time. A threshold word whose hysteresis byte is odd is never stored. Such a write instead puts the block into a lock state, which only a soft reset or a hardware reset clears.

The SPI pins are sampled by the system clock through synchronizers. The block therefore needs a system clock several times faster than the serial clock.

Top module: `disc_spi_regif`

## Requirements
- R1: Bit 7 of the command byte set selects a read and bit 7 clear selects a write; bits 6:0 of the command byte are the register address, so command 0xBC reads the register that command 0x3C writes.
- R2: MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge; every byte travels bit 7 first, and the first read data bit is on MISO before the first rising edge of the byte that follows the command.
- R3: Address 0x78 reads the channel bus as four bytes, bits 31:24 first; addresses 0x10, 0x12, 0x14 and 0x16 each read one byte: channels 7:0, 15:8, 23:16 and 31:24 in that order.
- R4: The control register at 0x02 is written with one data byte and reads back {6'b0, soft_reset, test}; bit 0 drives test_mode; while bit 1 is set, the sense-mode register is 0, both threshold words hold their reset value 0x0206, the lock is clear, and writes to those registers are ignored.
- R5: The sense-mode register at 0x04 is written with one data byte; its bits 3:0 (bit n for channels 8n+7:8n) drive bank_sense, and it reads back with bits 7:4 zero.
- R6: The threshold words at 0x3A (ground-open, thr_gnd) and 0x3C (supply-open, thr_sup) are written with a high byte (hysteresis) followed by a low byte (centre); both reset to 0x0206.
- R7: A complete threshold write whose high byte has bit 0 set leaves the word unchanged and sets locked.
- R8: While locked, every read returns zero bytes and every write is ignored, except a control write with bit 1 set, which clears the lock; a hardware reset also clears it.
- R9: Reads of addresses with no register return 0x00 bytes, and writes to them change no output.
- R10: Raising CS before a write's data is complete commits nothing, and the next frame starts with a new command byte.
- R11: Bytes clocked out after a read's defined length are 0x00.
- R12: MISO is 0 whenever CS has been inactive for at least three clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK by at least a factor of four |
| rst | input | 1 | Synchronous active-high hardware reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| chan_state | input | 32 | Current state of each sense channel |
| test_mode | output | 1 | Control bit 0 |
| bank_sense | output | 4 | Sensing mode per bank of eight channels, 1 = supply-open |
| thr_gnd | output | 16 | Ground-open threshold word {hysteresis, centre} |
| thr_sup | output | 16 | Supply-open threshold word {hysteresis, centre} |
| locked | output | 1 | Lock state after an odd hysteresis write |

## Verification
The hardest situation to reach from the ports is the lock state and the way out of it. Reaching it takes a complete three-byte threshold frame with an odd high byte. Ordinary traffic must then be seen to be blocked: reads of live status come back as zeros, and sense-mode writes and test-only control writes are dropped. After that, the only release paths are a control write carrying the soft-reset bit or a hardware reset pulse. The stimulus builds this sequence twice, once for each release path. It also runs frames cut off mid-byte and after only the hysteresis byte, so that a partial frame can be shown to leave no trace.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    localparam int ADDR_W = 7;
    localparam int IDX_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL    = 7'h02;
    localparam logic [ADDR_W-1:0] A_SENSE   = 7'h04;
    localparam logic [ADDR_W-1:0] A_LANE0   = 7'h10;
    localparam logic [ADDR_W-1:0] A_THR_GND = 7'h3A;
    localparam logic [ADDR_W-1:0] A_THR_SUP = 7'h3C;
    localparam logic [ADDR_W-1:0] A_WORD    = 7'h78;

    localparam int CTRL_TEST_BIT = 0;
    localparam int CTRL_SRST_BIT = 1;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } byte_evt_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.rd   = b[7];
        c.addr = b[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic is_thr_addr(input logic [ADDR_W-1:0] a);
        return (a == A_THR_GND) || (a == A_THR_SUP);
    endfunction

    function automatic logic [ADDR_W-1:0] lane_addr(input int lane);
        return ADDR_W'(int'(A_LANE0) + 2 * lane);
    endfunction

endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= RST_VAL;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= RST_VAL;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dspi_frame.sv
module dspi_frame
    import dspi_pkg::*;
#(
    parameter int TXW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk_s,
    input  logic           cs_n_s,
    input  logic           mosi_s,
    input  logic           load,
    input  logic [TXW-1:0] load_word,
    output byte_evt_t      evt,
    output logic           cs_act,
    output logic           miso
);
    logic             sclk_q;
    logic             rise;
    logic             fall;
    logic [2:0]       bit_cnt;
    logic [6:0]       rx_sh;
    logic [IDX_W-1:0] byte_idx;
    logic [TXW-1:0]   tx_sh;
    logic             skip_fall;

    assign cs_act = ~cs_n_s;
    assign rise   = cs_act & sclk_s & ~sclk_q;
    assign fall   = cs_act & ~sclk_s & sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_idx  <= '0;
            tx_sh     <= '0;
            skip_fall <= 1'b0;
            evt       <= '0;
        end else begin
            evt.valid <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    evt.valid <= 1'b1;
                    evt.idx   <= byte_idx;
                    evt.data  <= {rx_sh, mosi_s};
                    if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
                end
            end
            if (load) begin
                tx_sh     <= load_word;
                skip_fall <= 1'b1;
            end else if (fall) begin
                if (skip_fall) skip_fall <= 1'b0;
                else           tx_sh     <= {tx_sh[TXW-2:0], 1'b0};
            end
        end
    end

    assign miso = cs_act & tx_sh[TXW-1];
endmodule

// File: rtl/dspi_regs.sv
module dspi_regs
    import dspi_pkg::*;
#(
    parameter int          CHANNELS = 32,
    parameter logic [15:0] THR_RST  = 16'h0206,
    localparam int         NBANK    = CHANNELS / 8,
    localparam int         TXW      = CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  byte_evt_t           evt,
    input  logic [CHANNELS-1:0] chan,
    output logic                load,
    output logic [TXW-1:0]      load_word,
    output logic                test_mode,
    output logic                srst,
    output logic [NBANK-1:0]    bank_sense,
    output logic [15:0]         thr_gnd,
    output logic [15:0]         thr_sup,
    output logic                locked,
    output logic                odd_hit
);
    cmd_t       cmd_now;
    cmd_t       cmd_q;
    logic [7:0] hi_q;
    logic       wr_b1;
    logic       wr_b2;
    logic       ctrl_wr;
    logic       sense_wr;
    logic       thr_wr;

    logic [NBANK-1:0] lane_hit;
    logic [7:0]       lane_byte;

    assign cmd_now = decode_cmd(evt.data);
    assign load    = evt.valid && (evt.idx == '0) && cmd_now.rd;

    for (genvar j = 0; j < NBANK; j++) begin : g_lane
        assign lane_hit[j] = (cmd_now.addr == lane_addr(j));
    end

    always_comb begin
        lane_byte = '0;
        for (int j = 0; j < NBANK; j++) begin
            if (lane_hit[j]) lane_byte = lane_byte | chan[8*j +: 8];
        end
    end

    always_comb begin
        load_word = '0;
        if (!locked) begin
            if (cmd_now.addr == A_WORD) begin
                load_word = chan;
            end else if (cmd_now.addr == A_CTRL) begin
                load_word[TXW-1 -: 8] = {6'b0, srst, test_mode};
            end else if (cmd_now.addr == A_SENSE) begin
                load_word[TXW-1 -: 8] = 8'(bank_sense);
            end else if (cmd_now.addr == A_THR_GND) begin
                load_word[TXW-1 -: 16] = thr_gnd;
            end else if (cmd_now.addr == A_THR_SUP) begin
                load_word[TXW-1 -: 16] = thr_sup;
            end else if (|lane_hit) begin
                load_word[TXW-1 -: 8] = lane_byte;
            end
        end
    end

    assign wr_b1    = evt.valid && (evt.idx == IDX_W'(1)) && !cmd_q.rd;
    assign wr_b2    = evt.valid && (evt.idx == IDX_W'(2)) && !cmd_q.rd;
    assign ctrl_wr  = wr_b1 && (cmd_q.addr == A_CTRL) &&
                      (!locked || evt.data[CTRL_SRST_BIT]);
    assign sense_wr = wr_b1 && (cmd_q.addr == A_SENSE) && !locked && !srst;
    assign thr_wr   = wr_b2 && is_thr_addr(cmd_q.addr) && !locked && !srst;
    assign odd_hit  = thr_wr && hi_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            hi_q       <= '0;
            test_mode  <= 1'b0;
            srst       <= 1'b0;
            bank_sense <= '0;
            thr_gnd    <= THR_RST;
            thr_sup    <= THR_RST;
            locked     <= 1'b0;
        end else begin
            if (evt.valid && evt.idx == '0) cmd_q <= cmd_now;
            if (evt.valid && evt.idx == IDX_W'(1)) hi_q <= evt.data;

            if (ctrl_wr) begin
                test_mode <= evt.data[CTRL_TEST_BIT];
                srst      <= evt.data[CTRL_SRST_BIT];
                if (evt.data[CTRL_SRST_BIT]) begin
                    bank_sense <= '0;
                    thr_gnd    <= THR_RST;
                    thr_sup    <= THR_RST;
                    locked     <= 1'b0;
                end
            end

            if (sense_wr) bank_sense <= evt.data[NBANK-1:0];

            if (thr_wr) begin
                if (hi_q[0])                      locked  <= 1'b1;
                else if (cmd_q.addr == A_THR_GND) thr_gnd <= {hi_q, evt.data};
                else                              thr_sup <= {hi_q, evt.data};
            end
        end
    end
endmodule

// File: rtl/disc_spi_regif.sv
module disc_spi_regif
    import dspi_pkg::*;
#(
    parameter int          CHANNELS    = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] THR_RST     = 16'h0206,
    localparam int         NBANK       = CHANNELS / 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [CHANNELS-1:0] chan_state,
    output logic                test_mode,
    output logic [NBANK-1:0]    bank_sense,
    output logic [15:0]         thr_gnd,
    output logic [15:0]         thr_sup,
    output logic                locked
);
    logic [2:0]          pins_s;
    byte_evt_t           evt;
    logic                cs_act;
    logic                load;
    logic [CHANNELS-1:0] load_word;
    logic                srst;
    logic                odd_hit;

    dspi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   (pins_s)
    );

    dspi_frame #(
        .TXW (CHANNELS)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .load      (load),
        .load_word (load_word),
        .evt       (evt),
        .cs_act    (cs_act),
        .miso      (spi_miso)
    );

    dspi_regs #(
        .CHANNELS (CHANNELS),
        .THR_RST  (THR_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .chan       (chan_state),
        .load       (load),
        .load_word  (load_word),
        .test_mode  (test_mode),
        .srst       (srst),
        .bank_sense (bank_sense),
        .thr_gnd    (thr_gnd),
        .thr_sup    (thr_sup),
        .locked     (locked),
        .odd_hit    (odd_hit)
    );
endmodule

// File: rtl/disc_spi_regif_chk.sv
module disc_spi_regif_chk #(
    parameter int          NBANK   = 4,
    parameter logic [15:0] THR_RST = 16'h0206
) (
    input logic             clk,
    input logic             rst,
    input logic             spi_cs_n,
    input logic             spi_miso,
    input logic [NBANK-1:0] bank_sense,
    input logic [15:0]      thr_gnd,
    input logic [15:0]      thr_sup,
    input logic             locked,
    input logic             srst,
    input logic             odd_hit
);
    a_r12_miso_idle: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) |-> !spi_miso);

    a_r7_lock_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(odd_hit));

    a_r8_locked_frozen: assert property (@(posedge clk) disable iff (rst)
        locked && $past(locked) |->
            $stable(thr_gnd) && $stable(thr_sup) && $stable(bank_sense));

    a_r6_even_hyst: assert property (@(posedge clk) disable iff (rst)
        !thr_gnd[8] && !thr_sup[8]);

    a_r4_srst_defaults: assert property (@(posedge clk) disable iff (rst)
        srst |-> thr_gnd == THR_RST && thr_sup == THR_RST &&
                 bank_sense == '0 && !locked);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
        |=> $stable(thr_gnd) && $stable(thr_sup) && $stable(bank_sense) &&
            $stable(locked));
endmodule

bind disc_spi_regif disc_spi_regif_chk #(
    .NBANK   (NBANK),
    .THR_RST (THR_RST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .bank_sense (bank_sense),
    .thr_gnd    (thr_gnd),
    .thr_sup    (thr_sup),
    .locked     (locked),
    .srst       (srst),
    .odd_hit    (odd_hit)
);

// File: tb/disc_spi_regif_tb.sv
module disc_spi_regif_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        sclk, cs_n, mosi;
    logic        miso;
    logic [31:0] chan;
    logic        test_mode;
    logic [3:0]  bank_sense;
    logic [15:0] thr_gnd, thr_sup;
    logic        locked;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    logic [7:0] tx_b [8];
    logic [7:0] rx_b [8];

    // reference model state
    logic       m_test, m_srst, m_lock;
    logic [3:0] m_sense;
    logic [15:0] m_thg, m_ths;

    always #5 clk = ~clk;

    disc_spi_regif u_dut (
        .clk        (clk),
        .rst        (rst),
        .spi_sclk   (sclk),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .chan_state (chan),
        .test_mode  (test_mode),
        .bank_sense (bank_sense),
        .thr_gnd    (thr_gnd),
        .thr_sup    (thr_sup),
        .locked     (locked)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_test = 0; m_srst = 0; m_lock = 0; m_sense = 0;
        m_thg = 16'h0206; m_ths = 16'h0206;
    endtask

    task automatic model_apply(input int nb);
        logic [6:0] a;
        if (nb < 2 || tx_b[0][7]) return;
        a = tx_b[0][6:0];
        if (a == 7'h02) begin
            if (!m_lock || tx_b[1][1]) begin
                m_test = tx_b[1][0];
                m_srst = tx_b[1][1];
                if (tx_b[1][1]) begin
                    m_sense = 0; m_thg = 16'h0206; m_ths = 16'h0206; m_lock = 0;
                end
            end
        end else if (m_lock || m_srst) begin
            // blocked
        end else if (a == 7'h04) begin
            m_sense = tx_b[1][3:0];
        end else if ((a == 7'h3A || a == 7'h3C) && nb >= 3) begin
            if (tx_b[1][0])       m_lock = 1;
            else if (a == 7'h3A)  m_thg = {tx_b[1], tx_b[2]};
            else                  m_ths = {tx_b[1], tx_b[2]};
        end
    endtask

    function automatic logic [7:0] model_read(input logic [6:0] a, input int k);
        if (m_lock) return 8'h00;
        case (a)
            7'h78: return (k < 4) ? chan[31 - 8*k -: 8] : 8'h00;
            7'h10: return (k == 0) ? chan[7:0]   : 8'h00;
            7'h12: return (k == 0) ? chan[15:8]  : 8'h00;
            7'h14: return (k == 0) ? chan[23:16] : 8'h00;
            7'h16: return (k == 0) ? chan[31:24] : 8'h00;
            7'h02: return (k == 0) ? {6'b0, m_srst, m_test} : 8'h00;
            7'h04: return (k == 0) ? {4'b0, m_sense} : 8'h00;
            7'h3A: return (k == 0) ? m_thg[15:8] : (k == 1) ? m_thg[7:0] : 8'h00;
            7'h3C: return (k == 0) ? m_ths[15:8] : (k == 1) ? m_ths[7:0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic frame(input int nbytes, input int nbits);
        int sent = 0;
        cmp_en = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            rx_b[b] = 8'h00;
            for (int i = 7; i >= 0; i--) begin
                if (sent < nbits) begin
                    mosi = tx_b[b][i];
                    repeat (HALF) @(negedge clk);
                    rx_b[b][i] = miso;
                    sclk = 1'b1;
                    repeat (HALF) @(negedge clk);
                    sclk = 1'b0;
                    sent++;
                end
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        model_apply(nbits / 8);
        cmp_en = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] d0,
                            input logic [7:0] d1, input int nbytes);
        tx_b[0] = cmd; tx_b[1] = d0; tx_b[2] = d1;
        frame(nbytes, nbytes * 8);
    endtask

    task automatic do_read(input logic [7:0] cmd, input int ndata, input string tag);
        tx_b[0] = cmd;
        for (int k = 1; k < 8; k++) tx_b[k] = 8'hA5;
        frame(ndata + 1, (ndata + 1) * 8);
        for (int k = 0; k < ndata; k++) begin
            logic [7:0] e;
            e = model_read(cmd[6:0], k);
            chk(rx_b[k+1] === e, $sformatf("%s addr=%h byte%0d", tag, cmd[6:0], k),
                32'(rx_b[k+1]), 32'(e));
        end
    endtask

    // per-clock comparison of configuration outputs against the model
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk(test_mode === m_test, "R4 test_mode", 32'(test_mode), 32'(m_test));
            chk(bank_sense === m_sense, "R5 bank_sense", 32'(bank_sense), 32'(m_sense));
            chk(thr_gnd === m_thg, "R6 thr_gnd", 32'(thr_gnd), 32'(m_thg));
            chk(thr_sup === m_ths, "R6 thr_sup", 32'(thr_sup), 32'(m_ths));
            chk(locked === m_lock, "R7 locked", 32'(locked), 32'(m_lock));
            chk(miso === 1'b0, "R12 miso idle", 32'(miso), 32'd0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; chan = 32'h0;
        model_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        cmp_en = 1'b1;

        // reset state: R4 control reads zero, R6 default thresholds
        do_read(8'h82, 1, "R4 reset ctrl");
        do_read(8'hBA, 2, "R6 reset thr_gnd");

        // R3 status views, R11 trailing zeros, R2 byte order
        chan = 32'hDEADBEEF;
        do_read(8'hF8, 6, "R3 R11 word");
        do_read(8'h90, 2, "R3 lane0");
        do_read(8'h92, 2, "R3 lane1");
        do_read(8'h94, 2, "R3 lane2");
        do_read(8'h96, 3, "R3 R11 lane3");
        chan = 32'h12345678;
        do_read(8'hF8, 4, "R3 word2");

        // R5 sense-mode register
        do_write(8'h04, 8'hFA, 8'h00, 2);
        do_read(8'h84, 1, "R5 sense");

        // R6 thresholds, R2 high byte first, R1 read/write by bit 7
        do_write(8'h3A, 8'h04, 8'h0C, 3);
        do_write(8'h3C, 8'h06, 8'h10, 3);
        do_read(8'hBA, 3, "R6 R11 thr_gnd");
        do_read(8'hBC, 2, "R1 thr_sup via read cmd");

        // R4 test bit
        do_write(8'h02, 8'h01, 8'h00, 2);
        do_read(8'h82, 1, "R4 test");

        // R9 unmapped addresses
        do_write(8'h20, 8'h55, 8'h00, 2);
        do_write(8'h78, 8'hFF, 8'hFF, 3);
        do_read(8'hA0, 2, "R9 0x20");
        do_read(8'h91, 1, "R9 0x11");
        do_read(8'hFF, 1, "R9 0x7F");

        // R10 aborted frames
        tx_b[0] = 8'h04; tx_b[1] = 8'h05;
        frame(2, 13);
        do_read(8'h84, 1, "R10 sense after abort");
        do_write(8'h3A, 8'h08, 8'h00, 2);
        do_read(8'hBA, 2, "R10 thr after short frame");

        // R4 soft reset holds defaults and blocks writes
        do_write(8'h02, 8'h02, 8'h00, 2);
        do_write(8'h3A, 8'h0A, 8'h20, 3);
        do_write(8'h04, 8'h0F, 8'h00, 2);
        do_read(8'h82, 1, "R4 srst ctrl");
        do_read(8'hBA, 2, "R4 srst thr");
        do_write(8'h02, 8'h00, 8'h00, 2);

        // R7 odd hysteresis locks, R8 lock behaviour
        do_write(8'h3C, 8'h08, 8'h14, 3);
        do_write(8'h3A, 8'h03, 8'h10, 3);
        do_read(8'hF8, 4, "R8 locked status");
        do_read(8'hBA, 2, "R7 R8 locked thr");
        do_write(8'h04, 8'h03, 8'h00, 2);
        do_write(8'h02, 8'h01, 8'h00, 2);
        do_write(8'h02, 8'h02, 8'h00, 2);
        do_write(8'h02, 8'h00, 8'h00, 2);
        do_read(8'hBC, 2, "R8 released thr_sup");
        do_read(8'hF8, 4, "R8 released status");

        // R8 hardware reset clears lock
        do_write(8'h3C, 8'h01, 8'h00, 3);
        chk(locked === 1'b1, "R7 lock set", 32'(locked), 32'd1);
        @(negedge clk);
        cmp_en = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; model_reset();
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        chk(locked === 1'b0, "R8 hw reset", 32'(locked), 32'd0);
        do_read(8'h90, 1, "R8 after hw reset");

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule